// File: doc/BRIEF.md
# Teletext Packet Selective Dehammer

This block sits after a teletext slicer that has already framed packets into bytes. It receives one packet at a time, a fixed number of bytes long (42 by default), one byte on each cycle that the valid strobe is high, with a start marker on the first byte. For every accepted byte it produces one output byte on the following cycle. Each output byte is either a Hamming 8/4 decoded nibble or the input byte unchanged, and a flag marks which case applies. Two further flags report a double-bit Hamming error and the last byte of a packet.

Which positions are decoded depends on the kind of packet. The kind is worked out from the packet's own leading decoded bytes. The magazine byte and the row byte give the row number. For the service row, the design code in the third byte gives the format. A downstream parser can then take the decoded page, control, time or delivery fields as clean nibbles, while payload and status bytes reach it untouched. The class found so far is output with every byte.

Top module: `ttx_dehammer`

## Requirements
- R1: Each accepted byte appears at the output exactly one cycle later, with `out_valid` high and `out_idx` holding its 1-based position. A byte is accepted when `in_valid` is high and either `in_sop` is high or the current packet has between 1 and 41 bytes so far. Bytes that arrive while no packet is open, or after byte 42, are dropped, and `out_valid` stays low for them. `out_last` is high exactly when byte 42 is output.
- R2: A valid Hamming 8/4 codeword has data bits d0..d3 at bit positions 1, 3, 5 and 7. Its checks over bits {0,1,5,7}, {1,2,3,7} and {1,3,4,5} each have odd parity, and the whole byte has odd parity. A decoded byte is output as `{4'b0000, d3 d2 d1 d0}`. Any single flipped bit is corrected.
- R3: A decoded byte with a two-bit error sets `out_hamerr`, and its nibble is the uncorrected data bits. A decoded byte with no error, or with a corrected single error, leaves `out_hamerr` low.
- R4: Bytes 1 and 2 are always decoded. The row number is {byte-2 nibble, bit 3 of the byte-1 nibble}, which gives 5 bits.
- R5: In row 0 (header), bytes 1 to 10 are decoded and bytes 11 to 42 are raw.
- R6: In rows 1 to 25 (text), only bytes 1 and 2 are decoded.
- R7: In row 30, a third-byte design code of 0 or 1 selects format 1, and a code of 2 or 3 selects format 2. In both formats bytes 1 to 23 are decoded and bytes 24 to 42 are raw.
- R8: In rows 26 to 31 not covered by R7, including row 30 with a design code of 4 or more, bytes 1 to 3 are decoded and the rest are raw.
- R9: `out_class` is 0 on byte 1. From byte 2 it is 1 for header, 2 for text and 3 for extension rows. On bytes 3 to 42 of row 30 it becomes 4 for format 1 or 5 for format 2 when R7 applies, and otherwise it stays 3. It does not change after byte 3.
- R10: A start marker before byte 42 abandons the current packet. That byte becomes byte 1 of a new packet, and it is classified afresh.
- R11: A raw byte is output bit-for-bit equal to the input, with `out_dehammed` and `out_hamerr` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte strobe |
| in_sop | input | 1 | First byte of a packet |
| in_byte | input | 8 | Input byte |
| out_valid | output | 1 | Output byte strobe |
| out_byte | output | 8 | Decoded nibble (zero-extended) or raw byte |
| out_dehammed | output | 1 | Output byte was Hamming decoded |
| out_hamerr | output | 1 | Uncorrectable error in a decoded byte |
| out_idx | output | 6 | 1-based byte position in the packet |
| out_class | output | 3 | Packet class: 0 none, 1 header, 2 text, 3 extension, 4 format 1, 5 format 2 |
| out_last | output | 1 | Final byte of a packet |

## Verification
On every cycle, the assertions check the rules that can be read from the outputs alone. Positions step by one within a packet and never pass 42. The leading two bytes are always decoded, and a decoded byte has a zero upper nibble. Raw bytes never carry an error flag. The class holds after byte 3, and each class keeps to its decoded span. The bench scenarios show what depends on input content. These are the corrected nibble values and the detection of double errors, the mapping from row and design code to a class, including the rejected design codes. They also cover dropped bytes outside a packet and the restart when a start marker arrives mid-packet.

// File: rtl/ttx_dehammer.sv
module ttx_dehammer #(
  parameter int PKT_BYTES = 42,
  parameter int HDR_LAST  = 10,
  parameter int SVC_LAST  = 23,
  parameter int EXT_LAST  = 3,
  parameter int TEXT_ROWS = 25,
  parameter int SVC_ROW   = 30,
  localparam int IW = $clog2(PKT_BYTES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_sop,
  input  logic [7:0]    in_byte,
  output logic          out_valid,
  output logic [7:0]    out_byte,
  output logic          out_dehammed,
  output logic          out_hamerr,
  output logic [IW-1:0] out_idx,
  output logic [2:0]    out_class,
  output logic          out_last
);

  localparam logic [2:0] C_NONE = 3'd0, C_HDR = 3'd1, C_TXT = 3'd2,
                         C_EXT  = 3'd3, C_F1  = 3'd4, C_F2  = 3'd5;
  localparam logic [IW-1:0] LEN   = IW'(PKT_BYTES);
  localparam logic [IW-1:0] L_HDR = IW'(HDR_LAST);
  localparam logic [IW-1:0] L_SVC = IW'(SVC_LAST);
  localparam logic [IW-1:0] L_EXT = IW'(EXT_LAST);
  localparam logic [IW-1:0] L_TXT = IW'(2);
  localparam logic [4:0]    R_TXT = 5'(TEXT_ROWS);
  localparam logic [4:0]    R_SVC = 5'(SVC_ROW);

  function automatic logic [4:0] ham84(input logic [7:0] b);
    logic [2:0] bad;
    logic [3:0] n;
    logic       e;
    bad = {~(b[1] ^ b[3] ^ b[4] ^ b[5]),
           ~(b[1] ^ b[2] ^ b[3] ^ b[7]),
           ~(b[0] ^ b[1] ^ b[5] ^ b[7])};
    n = {b[7], b[5], b[3], b[1]};
    e = 1'b0;
    if (!(^b)) begin
      case (bad)
        3'b111:  n[0] = ~n[0];
        3'b110:  n[1] = ~n[1];
        3'b101:  n[2] = ~n[2];
        3'b011:  n[3] = ~n[3];
        default: ;
      endcase
    end else begin
      e = (bad != 3'b000);
    end
    return {e, n};
  endfunction

  logic [IW-1:0] cnt;
  logic          mag3;
  logic [4:0]    row_q;
  logic [2:0]    cls_q, cls_cur;
  logic [IW-1:0] lim;

  wire [4:0]    hd     = ham84(in_byte);
  wire [4:0]    row_now = {hd[3:0], mag3};
  wire          take   = in_valid && (in_sop || (cnt != '0 && cnt < LEN));
  wire [IW-1:0] idx    = in_sop ? IW'(1) : cnt + 1'b1;
  wire          deham  = idx <= lim;

  always_comb begin
    if (idx == IW'(1))
      cls_cur = C_NONE;
    else if (idx == IW'(2))
      cls_cur = (row_now == 5'd0) ? C_HDR : (row_now <= R_TXT) ? C_TXT : C_EXT;
    else if (idx == IW'(3) && row_q == R_SVC && hd[3:2] == 2'b00)
      cls_cur = hd[1] ? C_F2 : C_F1;
    else
      cls_cur = cls_q;
  end

  always_comb begin
    case (cls_cur)
      C_HDR:      lim = L_HDR;
      C_EXT:      lim = L_EXT;
      C_F1, C_F2: lim = L_SVC;
      default:    lim = L_TXT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt          <= '0;
      mag3         <= 1'b0;
      row_q        <= '0;
      cls_q        <= C_NONE;
      out_valid    <= 1'b0;
      out_byte     <= '0;
      out_dehammed <= 1'b0;
      out_hamerr   <= 1'b0;
      out_idx      <= '0;
      out_class    <= C_NONE;
    end else begin
      out_valid <= take;
      if (take) begin
        cnt <= idx;
        if (idx == IW'(1)) mag3  <= hd[3];
        if (idx == IW'(2)) row_q <= row_now;
        cls_q        <= cls_cur;
        out_byte     <= deham ? {4'b0000, hd[3:0]} : in_byte;
        out_dehammed <= deham;
        out_hamerr   <= deham & hd[4];
        out_idx      <= idx;
        out_class    <= cls_cur;
      end
    end
  end

  assign out_last = out_valid && out_idx == LEN;

  logic [IW-1:0] prev_idx;
  logic [2:0]    prev_cls;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_idx <= '0;
      prev_cls <= C_NONE;
    end else if (out_valid) begin
      prev_idx <= out_idx;
      prev_cls <= out_class;
    end
  end

  a_r1_idx_step: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_idx != IW'(1) |-> out_idx == prev_idx + 1'b1);
  a_r1_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_idx != '0 && out_idx <= LEN);
  a_r4_lead_decoded: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_idx <= IW'(2) |-> out_dehammed);
  a_r2_nibble_form: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_dehammed |-> out_byte[7:4] == 4'b0000);
  a_r11_raw_clean: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_dehammed |-> !out_hamerr);
  a_r9_class_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_idx > IW'(3) |-> out_class == prev_cls);
  a_r5_header_span: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_class == C_HDR |-> out_dehammed == (out_idx <= L_HDR));
  a_r6_text_span: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_class == C_TXT |-> out_dehammed == (out_idx <= L_TXT));
  a_r7_svc_span: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (out_class == C_F1 || out_class == C_F2) |-> out_dehammed == (out_idx <= L_SVC));
  a_r8_ext_span: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_class == C_EXT && out_idx > IW'(2) |-> out_dehammed == (out_idx <= L_EXT));

endmodule

// File: tb/ttx_dehammer_bench.sv
module ttx_dehammer_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0, in_sop = 1'b0;
  logic [7:0] in_byte = '0;
  logic       out_valid, out_dehammed, out_hamerr, out_last;
  logic [7:0] out_byte;
  logic [5:0] out_idx;
  logic [2:0] out_class;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ttx_dehammer u_ttx_dehammer (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
    .in_byte(in_byte), .out_valid(out_valid), .out_byte(out_byte), .out_dehammed(out_dehammed),
    .out_hamerr(out_hamerr), .out_idx(out_idx), .out_class(out_class), .out_last(out_last));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] enc(input logic [3:0] d);
    logic [7:0] b;
    b[1] = d[0]; b[3] = d[1]; b[5] = d[2]; b[7] = d[3];
    b[0] = ~(d[0] ^ d[2] ^ d[3]);
    b[2] = ~(d[0] ^ d[1] ^ d[3]);
    b[4] = ~(d[0] ^ d[1] ^ d[2]);
    b[6] = 1'b0;
    b[6] = ~(^b);
    return b;
  endfunction

  function automatic logic [4:0] ref_dec(input logic [7:0] b);
    for (int v = 0; v < 16; v++)
      if ($countones(enc(4'(v)) ^ b) <= 1) return {1'b0, 4'(v)};
    return {1'b1, b[7], b[5], b[3], b[1]};
  endfunction

  task automatic put(input logic sop, input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1; in_sop = sop; in_byte = b;
    @(posedge clk); #1;
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0; in_sop = 1'b0;
  endtask

  task automatic run_pkt(input logic [4:0] row, input logic [3:0] code, input int nbytes,
                         input int errpos, input logic [7:0] errmask, input int seed, input string tag);
    int cls, lim;
    if (row == 0) begin cls = 1; lim = 10; end
    else if (row <= 25) begin cls = 2; lim = 2; end
    else if (row == 30 && code <= 1) begin cls = 4; lim = 23; end
    else if (row == 30 && code <= 3) begin cls = 5; lim = 23; end
    else begin cls = 3; lim = 3; end
    for (int i = 1; i <= nbytes; i++) begin
      logic [7:0] b, e;
      logic [4:0] r;
      int ecls;
      bit dh;
      if (i == 1) b = enc({row[0], 3'(seed)});
      else if (i == 2) b = enc(row[4:1]);
      else if (i == 3) b = enc(code);
      else if (i <= lim) b = enc(4'(i + seed));
      else b = 8'(i * 13 + seed);
      if (i == errpos) b = b ^ errmask;
      put(i == 1, b);
      dh = (i <= lim);
      ecls = (i == 1) ? 0 : (i == 2) ? ((row == 0) ? 1 : (row <= 25) ? 2 : 3) : cls;
      r = ref_dec(b);
      e = dh ? {4'b0000, r[3:0]} : b;
      chk(out_valid && out_idx == 6'(i), {tag, " R1 position"}, int'(out_idx), i);
      chk(out_last == (i == 42), {tag, " R1 last flag"}, int'(out_last), int'(i == 42));
      chk(out_dehammed == dh, {tag, (i <= 2) ? " R4 lead decode" : " span"}, int'(out_dehammed), int'(dh));
      chk(out_byte == e, {tag, dh ? " R2 decoded value" : " R11 raw value"}, int'(out_byte), int'(e));
      chk(out_hamerr == (dh && r[4]), {tag, " R3 error flag"}, int'(out_hamerr), int'(dh && r[4]));
      chk(out_class == 3'(ecls), {tag, " R9 class"}, int'(out_class), ecls);
    end
  endtask

  task automatic t_reset();
    chk(!out_valid && !out_last && out_class == 0 && out_idx == 0, "R1 reset state", int'(out_valid), 0);
  endtask

  task automatic t_stray();
    put(1'b0, 8'h5A);
    chk(!out_valid, "R1 byte outside packet dropped", int'(out_valid), 0);
    put(1'b0, 8'hC3);
    chk(!out_valid, "R1 byte outside packet dropped", int'(out_valid), 0);
    idle();
  endtask

  task automatic t_header();  run_pkt(5'd0, 4'd6, 42, 0, 8'h00, 3, "R5 header"); endtask
  task automatic t_text();    run_pkt(5'd17, 4'd9, 42, 0, 8'h00, 5, "R6 text"); run_pkt(5'd25, 4'd1, 42, 0, 8'h00, 2, "R6 text edge"); endtask
  task automatic t_fmt1();    run_pkt(5'd30, 4'd1, 42, 0, 8'h00, 1, "R7 format1"); endtask
  task automatic t_fmt2();    run_pkt(5'd30, 4'd2, 42, 0, 8'h00, 6, "R7 format2"); endtask
  task automatic t_ext();     run_pkt(5'd27, 4'd0, 42, 0, 8'h00, 4, "R8 extension"); run_pkt(5'd26, 4'd3, 42, 0, 8'h00, 7, "R8 extension 26"); endtask
  task automatic t_badcode(); run_pkt(5'd30, 4'd5, 42, 0, 8'h00, 2, "R8 row30 bad code"); endtask

  task automatic t_errors();
    run_pkt(5'd0, 4'd3, 42, 6, 8'h08, 1, "R2 single error data bit");
    run_pkt(5'd0, 4'd3, 42, 2, 8'h40, 2, "R2 single error parity bit");
    run_pkt(5'd30, 4'd0, 42, 15, 8'h22, 0, "R3 double error");
    run_pkt(5'd17, 4'd0, 42, 30, 8'h22, 0, "R11 raw with flips");
  endtask

  task automatic t_abort();
    run_pkt(5'd0, 4'd2, 20, 0, 8'h00, 1, "R10 aborted header");
    run_pkt(5'd30, 4'd3, 42, 0, 8'h00, 5, "R10 restart format2");
    put(1'b0, 8'hA5);
    chk(!out_valid, "R1 byte after 42 dropped", int'(out_valid), 0);
    idle();
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 t_reset();
    @(negedge clk) rst_n = 1'b1;
    t_stray();
    t_header();
    t_text();
    t_fmt1();
    t_fmt2();
    t_ext();
    t_badcode();
    idle();
    t_errors();
    t_abort();
    repeat (3) @(posedge clk);
    done = 1;
    summary();
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end
endmodule